// File: doc/BRIEF.md
# Interrupt Entry Stack Sequencer

This block carries out the processor side of entering an interrupt handler once an interrupt type number has been accepted. On a start request it takes a snapshot of the flags, code segment, instruction pointer, stack pointer and stack segment. It then saves the machine state on the stack with three word writes and masks further maskable and single-step interrupts. After that it reads the handler's entry point from a vector table in memory, and finally raises a one-cycle completion pulse so that fetching can resume at the new CS:IP.

All memory traffic goes through one synchronous request port. The port carries a request, a write strobe, a 20-bit physical address, write data, read data and a ready input. A transfer completes on a rising clock edge at which both request and ready are high. The architectural registers are visible on outputs at all times, so the surrounding core can take the handler address and the new stack pointer directly from them.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, busy, done and mem_req are low, and flags_q, cs_q, ip_q and sp_q are zero.
- R2: When start is high and busy is low at a clock edge, the inputs are captured. From the next cycle busy is high and the first request is a write of the captured flags to physical address (SS*16 + SP - 2) mod 2^20.
- R3: The three stack writes go in the order flags, then CS, then IP. SP is reduced by 2 before each write, so the addresses are SS*16 + SP-2, SP-4 and SP-6 (the offset wraps mod 2^16 and the sum wraps mod 2^20). The final sp_q is (SP - 6) mod 2^16.
- R4: Once the flags word has been written, bit 9 (interrupt enable) and bit 8 (trap) of flags_q are zero and every other bit is kept. Both bits are already zero when the first vector read is issued.
- R5: The vector reads come only after all three writes. The first reads the new IP at physical address n*4 and the second reads the new CS at n*4 + 2, where n is the captured type number.
- R6: While mem_req is high and mem_rdy is low, mem_req, mem_we, mem_addr and mem_wdata hold their values. Each transfer completes on an edge where mem_req and mem_rdy are both high.
- R7: done is high for exactly one cycle, in the cycle after the second vector read completes, and busy falls in the cycle after that. With w wait cycles per access, done appears 5(w+1)+1 cycles after the start edge.
- R8: A start request while busy is high is ignored. The running sequence keeps its captured type number and register values.
- R9: After done, ip_q and cs_q hold the words returned by the first and second vector reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an entry sequence (taken only when idle) |
| vec_type | input | 8 | Interrupt type number |
| in_flags | input | 16 | Current flags word |
| in_cs | input | 16 | Current code segment |
| in_ip | input | 16 | Current instruction pointer |
| in_sp | input | 16 | Current stack pointer |
| in_ss | input | 16 | Current stack segment |
| busy | output | 1 | Sequence in progress, including the done cycle |
| done | output | 1 | One-cycle pulse once CS and IP are loaded |
| flags_q | output | 16 | Flags register |
| cs_q | output | 16 | Code segment register |
| ip_q | output | 16 | Instruction pointer register |
| sp_q | output | 16 | Stack pointer register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 20 | Physical address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Transfer completes at this edge |

## Verification
Each access is due one cycle after the previous transfer edge, and it then lasts w+1 cycles for a responder that inserts w wait cycles. done is therefore due exactly 5(w+1)+1 cycles after the start edge. The bench counts falling edges from the start edge and checks done at that count and no earlier. The memory model runs on the falling edge: it records every transfer and checks that address and data hold through the wait cycles. It also samples flags_q on each read, so the ordering and the flag clearing are checked per access and not only at the end of a run.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  localparam int WORD_W = 16;
  localparam int PA_W   = 20;
  localparam int SEG_SH = 4;
  localparam int TYPE_W = 8;
  localparam int STEP   = 2;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PSH_FL = 3'd1,
    ST_PSH_CS = 3'd2,
    ST_PSH_IP = 3'd3,
    ST_RD_IP  = 3'd4,
    ST_RD_CS  = 3'd5,
    ST_DONE   = 3'd6
  } seq_st_e;

  // segment:offset to physical, wrapping at PA_W bits
  function automatic logic [PA_W-1:0] lin_addr(input logic [WORD_W-1:0] seg,
                                                input logic [WORD_W-1:0] off);
    logic [PA_W-1:0] s, o;
    s = {seg, {SEG_SH{1'b0}}};
    o = {{(PA_W-WORD_W){1'b0}}, off};
    return s + o;
  endfunction

  // vector slot for a type: word 0 is IP, word 1 is CS
  function automatic logic [PA_W-1:0] vec_addr(input logic [TYPE_W-1:0] typ,
                                               input logic              hi);
    logic [PA_W-1:0] base;
    base = {{(PA_W-TYPE_W-2){1'b0}}, typ, 2'b00};
    return base + (hi ? PA_W'(STEP) : '0);
  endfunction

  function automatic logic [WORD_W-1:0] sp_dec(input logic [WORD_W-1:0] sp);
    return sp - WORD_W'(STEP);
  endfunction

  function automatic logic [WORD_W-1:0] mask_flags(input logic [WORD_W-1:0] f,
                                                   input int ie_bit,
                                                   input int tr_bit);
    logic [WORD_W-1:0] r;
    r = f;
    r[ie_bit] = 1'b0;
    r[tr_bit] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    xfer,
  output seq_st_e st,
  output logic    ev_accept,
  output logic    busy,
  output logic    done,
  output logic    req,
  output logic    we
);

  seq_st_e st_nxt;

  assign ev_accept = (st == ST_IDLE) && start;

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE:   if (start) st_nxt = ST_PSH_FL;
      ST_PSH_FL: if (xfer)  st_nxt = ST_PSH_CS;
      ST_PSH_CS: if (xfer)  st_nxt = ST_PSH_IP;
      ST_PSH_IP: if (xfer)  st_nxt = ST_RD_IP;
      ST_RD_IP:  if (xfer)  st_nxt = ST_RD_CS;
      ST_RD_CS:  if (xfer)  st_nxt = ST_DONE;
      ST_DONE:              st_nxt = ST_IDLE;
      default:              st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  always_comb begin
    busy = (st != ST_IDLE);
    done = (st == ST_DONE);
    we   = (st == ST_PSH_FL) || (st == ST_PSH_CS) || (st == ST_PSH_IP);
    req  = we || (st == ST_RD_IP) || (st == ST_RD_CS);
  end

endmodule

// File: rtl/irq_entry_regs.sv
module irq_entry_regs
  import irq_entry_pkg::*;
#(
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  seq_st_e           st,
  input  logic              ev_accept,
  input  logic              xfer,
  input  logic [TYPE_W-1:0] vec_type,
  input  logic [WORD_W-1:0] in_flags,
  input  logic [WORD_W-1:0] in_cs,
  input  logic [WORD_W-1:0] in_ip,
  input  logic [WORD_W-1:0] in_sp,
  input  logic [WORD_W-1:0] in_ss,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] flags_q,
  output logic [WORD_W-1:0] cs_q,
  output logic [WORD_W-1:0] ip_q,
  output logic [WORD_W-1:0] sp_q,
  output logic [WORD_W-1:0] ss_q,
  output logic [TYPE_W-1:0] typ_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      cs_q    <= '0;
      ip_q    <= '0;
      sp_q    <= '0;
      ss_q    <= '0;
      typ_q   <= '0;
    end else if (ev_accept) begin
      flags_q <= in_flags;
      cs_q    <= in_cs;
      ip_q    <= in_ip;
      sp_q    <= sp_dec(in_sp);   // pre-decrement for the first push
      ss_q    <= in_ss;
      typ_q   <= vec_type;
    end else if (xfer) begin
      case (st)
        ST_PSH_FL: begin
          flags_q <= mask_flags(flags_q, IF_BIT, TF_BIT);
          sp_q    <= sp_dec(sp_q);
        end
        ST_PSH_CS: sp_q <= sp_dec(sp_q);
        ST_RD_IP:  ip_q <= rdata;
        ST_RD_CS:  cs_q <= rdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TYPE_W-1:0] vec_type,
  input  logic [WORD_W-1:0] in_flags,
  input  logic [WORD_W-1:0] in_cs,
  input  logic [WORD_W-1:0] in_ip,
  input  logic [WORD_W-1:0] in_sp,
  input  logic [WORD_W-1:0] in_ss,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] flags_q,
  output logic [WORD_W-1:0] cs_q,
  output logic [WORD_W-1:0] ip_q,
  output logic [WORD_W-1:0] sp_q,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_rdy
);

  seq_st_e           st;
  logic              ev_accept;
  logic              ev_xfer;
  logic [WORD_W-1:0] ss_q;
  logic [TYPE_W-1:0] typ_q;

  assign ev_xfer = mem_req && mem_rdy;

  irq_entry_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .xfer      (ev_xfer),
    .st        (st),
    .ev_accept (ev_accept),
    .busy      (busy),
    .done      (done),
    .req       (mem_req),
    .we        (mem_we)
  );

  irq_entry_regs #(.IF_BIT(IF_BIT), .TF_BIT(TF_BIT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .ev_accept (ev_accept),
    .xfer      (ev_xfer),
    .vec_type  (vec_type),
    .in_flags  (in_flags),
    .in_cs     (in_cs),
    .in_ip     (in_ip),
    .in_sp     (in_sp),
    .in_ss     (in_ss),
    .rdata     (mem_rdata),
    .flags_q   (flags_q),
    .cs_q      (cs_q),
    .ip_q      (ip_q),
    .sp_q      (sp_q),
    .ss_q      (ss_q),
    .typ_q     (typ_q)
  );

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      ST_PSH_FL: begin mem_addr = lin_addr(ss_q, sp_q); mem_wdata = flags_q; end
      ST_PSH_CS: begin mem_addr = lin_addr(ss_q, sp_q); mem_wdata = cs_q;    end
      ST_PSH_IP: begin mem_addr = lin_addr(ss_q, sp_q); mem_wdata = ip_q;    end
      ST_RD_IP:  mem_addr = vec_addr(typ_q, 1'b0);
      ST_RD_CS:  mem_addr = vec_addr(typ_q, 1'b1);
      default: ;
    endcase
  end

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
)(
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_rdy,
  input logic [19:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic [15:0] flags_q,
  input logic [15:0] cs_q,
  input logic [15:0] ip_q,
  input logic [15:0] sp_q
);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_req_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy && !done);

  assert_flags_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> !flags_q[IF_BIT] && !flags_q[TF_BIT]);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && mem_req && mem_we);

  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy && !done && !(mem_req && mem_rdy)
      |=> $stable(sp_q) && $stable(cs_q) && $stable(ip_q) && $stable(flags_q));

endmodule

bind irq_entry_seq irq_entry_chk #(.IF_BIT(IF_BIT), .TF_BIT(TF_BIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_rdy   (mem_rdy),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .flags_q   (flags_q),
  .cs_q      (cs_q),
  .ip_q      (ip_q),
  .sp_q      (sp_q)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  vec_type = '0;
  logic [15:0] in_flags = '0, in_cs = '0, in_ip = '0, in_sp = '0, in_ss = '0;
  logic        busy, done, mem_req, mem_we;
  logic [15:0] flags_q, cs_q, ip_q, sp_q, mem_wdata;
  logic [19:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        mem_rdy = 1'b0;

  always #2.5 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_type(vec_type),
    .in_flags(in_flags), .in_cs(in_cs), .in_ip(in_ip), .in_sp(in_sp), .in_ss(in_ss),
    .busy(busy), .done(done), .flags_q(flags_q), .cs_q(cs_q), .ip_q(ip_q), .sp_q(sp_q),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_word(input logic [19:0] a);
    int v;
    v = ((int'(a) * 3) + 16'h1D7) & 16'hFFFF;
    return 16'(v ^ 16'h6B2D);
  endfunction

  function automatic int phys(input int seg, input int off);
    return (seg * 16 + off) % 1048576;
  endfunction

  // responder model on the falling edge
  int          wait_n = 0;
  int          wcnt = 0;
  logic [19:0] held_a;
  logic [15:0] held_d;
  bit          hold_bad = 0;
  int          log_n = 0;
  logic [19:0] log_a [5];
  logic [15:0] log_d [5];
  bit          log_w [5];
  logic [15:0] log_f [5];

  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt == 0) begin
        held_a = mem_addr;
        held_d = mem_wdata;
      end else if (mem_addr != held_a || mem_wdata != held_d) begin
        hold_bad = 1;
      end
      if (wcnt == wait_n) begin
        mem_rdy   = 1'b1;
        mem_rdata = mem_word(mem_addr);
        if (log_n < 5) begin
          log_a[log_n] = mem_addr;
          log_d[log_n] = mem_we ? mem_wdata : mem_word(mem_addr);
          log_w[log_n] = mem_we;
          log_f[log_n] = flags_q;
        end
        log_n++;
        wcnt = 0;
      end else begin
        mem_rdy = 1'b0;
        wcnt++;
      end
    end else begin
      mem_rdy = 1'b0;
      wcnt = 0;
    end
  end

  task automatic run(input int typ, input int fl, input int cs, input int ip,
                     input int sp, input int ss, input int w, input bit poke);
    int cyc;
    int exp_off [3];
    int exp_dat [3];
    @(negedge clk);
    wait_n = w; log_n = 0; hold_bad = 0;
    vec_type = 8'(typ); in_flags = 16'(fl); in_cs = 16'(cs);
    in_ip = 16'(ip); in_sp = 16'(sp); in_ss = 16'(ss);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk(busy && mem_req && mem_we, "R2 busy and write after start", {busy, mem_req, mem_we}, 3'b111);
    while (!done && cyc < 100) begin
      if (poke && cyc == 2) begin
        start = 1'b1; vec_type = 8'(typ ^ 8'h3C);
        in_sp = 16'(sp ^ 16'h0F0F); in_cs = 16'(cs ^ 16'hFFFF);
      end
      if (poke && cyc == 4) start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 5 * (w + 1) + 1, "R7 done cycle", cyc, 5 * (w + 1) + 1);
    chk(log_n == 5, "R5 access count", log_n, 5);
    exp_dat[0] = fl; exp_dat[1] = cs; exp_dat[2] = ip;
    for (int k = 0; k < 3; k++) begin
      exp_off[k] = (sp - 2 * (k + 1) + 65536) % 65536;
      chk(log_w[k] == 1'b1, "R3 push is write", log_w[k], 1);
      chk(int'(log_a[k]) == phys(ss, exp_off[k]), "R3 push address", log_a[k], phys(ss, exp_off[k]));
      chk(int'(log_d[k]) == exp_dat[k], "R3 push data", log_d[k], exp_dat[k]);
    end
    chk(int'(log_d[0]) == fl, "R2 original flags saved", log_d[0], fl);
    for (int k = 3; k < 5; k++) begin
      chk(log_w[k] == 1'b0, "R5 vector access is read", log_w[k], 0);
      chk(int'(log_a[k]) == typ * 4 + (k - 3) * 2, "R5 vector address", log_a[k], typ * 4 + (k - 3) * 2);
      chk(log_f[k][9:8] == 2'b00, "R4 IF/TF clear before vector read", log_f[k], fl & 16'hFCFF);
    end
    chk(int'(flags_q) == (fl & 16'hFCFF), "R4 flags after entry", flags_q, fl & 16'hFCFF);
    chk(int'(sp_q) == (sp - 6 + 65536) % 65536, "R3 final SP", sp_q, (sp - 6 + 65536) % 65536);
    chk(ip_q == mem_word(20'(typ * 4)), "R9 new IP", ip_q, mem_word(20'(typ * 4)));
    chk(cs_q == mem_word(20'(typ * 4 + 2)), "R9 new CS", cs_q, mem_word(20'(typ * 4 + 2)));
    chk(!hold_bad, "R6 address/data held during wait", hold_bad, 0);
    if (poke) chk(int'(log_a[3]) == typ * 4, "R8 busy start ignored", log_a[3], typ * 4);
    @(negedge clk);
    chk(!busy && !done, "R7 idle after done pulse", {busy, done}, 0);
    if (poke) chk(!mem_req, "R8 no second sequence", mem_req, 0);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int types [4] = '{0, 1, 8'h55, 8'hFF};
    int sps   [4] = '{16'h0100, 16'h0000, 16'h0004, 16'hFFF0};
    int sss   [4] = '{16'h1000, 16'hFFFF, 16'h0000, 16'hF800};
    int fls   [4] = '{16'h0300, 16'hFFFF, 16'h0000, 16'h0A55};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_req, "R1 control outputs low", {busy, done, mem_req}, 0);
    chk(flags_q == 0 && cs_q == 0 && ip_q == 0 && sp_q == 0, "R1 registers zero",
        {flags_q, cs_q, ip_q, sp_q}, 0);
    rst_n = 1'b1;
    for (int t = 0; t < 4; t++) begin
      for (int w = 0; w < 3; w++) begin
        int i;
        i = (t + w) % 4;
        run(types[t], fls[i], 16'h1234 + t * 16'h0111, 16'hBEE0 + w, sps[i], sss[(t + 2 * w) % 4], w, (t + w) % 2 == 1);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule